// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Port

This block is a clocked, synthesizable model of the device side of a 16-bit asynchronous pseudo-static memory. A host drives active-low controls: chip select, write strobe, output enable and one enable per byte lane. It also drives a word address and write data. The block stores words in an internal array whose depth is a parameter. It returns read data on a separate output bus, with one drive flag per lane in place of a bidirectional bus. It also reports whether the part is active or in standby.

All controls are sampled on the system clock. A write is the overlap of chip select, write strobe and a lane enable, and each lane keeps its own overlap window. On the clock edge where a lane's overlap ends, that lane's byte is taken from the write-data bus and stored. A read is sampled on an edge and appears on the outputs after that edge.

Top module: `bytelane_psram_port`

## Requirements
- R1: A word is 16 bits. Lane 0 is bits 7:0 and is gated by `lane_en_n[0]`. Lane 1 is bits 15:8 and is gated by `lane_en_n[1]`. The address is 18 bits wide.
- R2: When an edge samples chip select low, write strobe high and output enable low, each lane whose enable is low has `lane_drive` set after that edge, and its `rdata` bits hold the stored byte.
- R3: After an edge that samples chip select high, output enable high, both lane enables high, or chip select and write strobe both low, `lane_drive` is 0. Any lane that is not driven reads as zero on `rdata`.
- R4: A write changes only the lanes whose enable was low during the overlap. The other lane of the word keeps its old value.
- R5: A lane's byte is taken from `wdata` on the edge at which that lane's overlap ends. Data present on earlier edges of the window has no effect.
- R6: The overlap of a lane ends when any one of chip select, write strobe or that lane's enable is sampled high. When one lane enable rises early, only that lane commits, and the other lane's window continues.
- R7: A read sampled on the same edge that ends a write to the same word returns the newly written byte.
- R8: `power_active` is 0 after an edge that samples chip select high or both lane enables high. Otherwise it is 1.
- R9: Synchronous active-low reset clears `lane_drive`, `rdata` and `power_active`. It also discards any open write window, so nothing is stored from it.
- R10: Addresses at or above the array depth wrap modulo the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all controls are sampled |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| lane_en_n | input | 2 | Active-low byte lane enables (bit 0 low lane, bit 1 high lane) |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data; lanes that are not driven read zero |
| lane_drive | output | 2 | Per-lane output drive flag (1 = lane drives, 0 = high impedance) |
| power_active | output | 1 | 1 when active, 0 in standby |

## Verification
The hardest cases to reach from the ports depend on which control ends a write and on what else happens at that same edge. Three of them matter most:
- One lane enable lifts while the other lane's window stays open.
- A write strobe rises on the very edge that starts a read of the same word.
- Reset lands while a window is open.

The bench drives explicit edge-by-edge control sequences to reach each of these. It then sweeps every combination of the five control levels, and it sweeps byte-masked writes over every word of a 16-word array, ending each write by a different control in turn. A reference array inside the bench follows the write windows from the requirements alone.

// File: rtl/psram_port_pkg.sv
`timescale 1ns/1ps
// Shared types for the byte-lane memory port.
// Assumes: nothing beyond the importing module's own parameters.
package psram_port_pkg;

    // Operating mode decoded from one set of sampled control levels
    typedef enum logic [1:0] {
        MODE_STANDBY   = 2'd0,
        MODE_READ      = 2'd1,
        MODE_WRITE     = 2'd2,
        MODE_NO_OUTPUT = 2'd3
    } port_mode_e;

endpackage

// File: rtl/psram_ctrl_decode.sv
`timescale 1ns/1ps
// Control decoder: turns the sampled active-low control levels into an
// operating mode, a per-lane write-overlap vector and a per-lane read vector.
// Assumes: the inputs are levels sampled on the current clock edge; the
// module is purely combinational.
module psram_ctrl_decode
    import psram_port_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                 chip_sel_n,
    input  logic                 wr_n,
    input  logic                 out_en_n,
    input  logic [NUM_LANES-1:0] lane_en_n,
    output logic [NUM_LANES-1:0] lane_win,
    output logic [NUM_LANES-1:0] lane_rd,
    output logic                 active
);

    port_mode_e mode;
    logic       any_lane;

    // Mode priority: standby first, then write, then read, else no output
    always_comb begin
        any_lane = ~(&lane_en_n);
        if (chip_sel_n || !any_lane) begin
            mode = MODE_STANDBY;
        end else if (!wr_n) begin
            mode = MODE_WRITE;
        end else if (!out_en_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_NO_OUTPUT;
        end
    end

    // Per-lane qualification of write overlap, read drive and activity
    always_comb begin
        lane_win = (mode == MODE_WRITE) ? ~lane_en_n : '0;
        lane_rd  = (mode == MODE_READ)  ? ~lane_en_n : '0;
        active   = (mode != MODE_STANDBY);
    end

endmodule

// File: rtl/psram_lane_writer.sv
`timescale 1ns/1ps
// Per-lane write window tracker: remembers whether the lane's overlap was
// open on the previous edge and which word it addressed, and flags a commit
// on the edge where the overlap closes.
// Assumes: the address is held steady while the window is open; the data
// for the commit is whatever is on the lane's data bits at the closing edge.
module psram_lane_writer #(
    parameter int IDX_W  = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_now,
    input  logic [IDX_W-1:0]  idx_now,
    input  logic [LANE_W-1:0] din,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [LANE_W-1:0] commit_data
);

    logic             win_q;
    logic [IDX_W-1:0] idx_q;

    // Track the open window and the word it targets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            idx_q <= '0;
        end else begin
            win_q <= win_now;
            if (win_now) begin
                idx_q <= idx_now;
            end
        end
    end

    // Close-of-window commit, suppressed while reset is held
    always_comb begin
        commit      = rst_n && win_q && !win_now;
        commit_idx  = idx_q;
        commit_data = din;
    end

endmodule

// File: rtl/psram_lane_store.sv
`timescale 1ns/1ps
// One byte lane of storage with a single write port and a combinational
// read port that forwards a same-edge write to the same word.
// Assumes: indices are always below DEPTH; contents are undefined until
// written (no reset on the array).
module psram_lane_store #(
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LANE_W-1:0] rd_data
);

    logic [LANE_W-1:0] cells [DEPTH];

    // Store the committed byte
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // Read with forwarding of a write landing on the same edge
    always_comb begin
        if (wr_en && (wr_idx == rd_idx)) begin
            rd_data = wr_data;
        end else begin
            rd_data = cells[rd_idx];
        end
    end

endmodule

// File: rtl/bytelane_psram_port.sv
`timescale 1ns/1ps
// Byte-lane asynchronous memory port (device side), clocked model.
// Samples active-low chip select, write strobe, output enable and per-lane
// enables on clk. Each lane has its own write window, committed on the edge
// where the window closes. Reads are registered, and lanes that are not
// driven read zero. power_active shows standby versus active.
// Assumes: controls are synchronous to clk; the address stays steady across
// a write window; addresses wrap modulo DEPTH.
module bytelane_psram_port #(
    parameter  int ADDR_W    = 18,
    parameter  int LANE_W    = 8,
    parameter  int NUM_LANES = 2,
    parameter  int DEPTH     = 1024,
    localparam int DATA_W    = LANE_W * NUM_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_sel_n,
    input  logic                 wr_n,
    input  logic                 out_en_n,
    input  logic [NUM_LANES-1:0] lane_en_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LANES-1:0] lane_drive,
    output logic                 power_active
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]     idx_now;
    logic [NUM_LANES-1:0] lane_win;
    logic [NUM_LANES-1:0] lane_rd;
    logic                 active_now;
    logic                 power_q;

    // Wrap the word address into the array
    always_comb begin
        idx_now = IDX_W'(addr % ADDR_W'(DEPTH));
    end

    psram_ctrl_decode #(
        .NUM_LANES (NUM_LANES)
    ) u_decode (
        .chip_sel_n (chip_sel_n),
        .wr_n       (wr_n),
        .out_en_n   (out_en_n),
        .lane_en_n  (lane_en_n),
        .lane_win   (lane_win),
        .lane_rd    (lane_rd),
        .active     (active_now)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic              commit;
        logic [IDX_W-1:0]  commit_idx;
        logic [LANE_W-1:0] commit_data;
        logic [LANE_W-1:0] rd_byte;
        logic              drv_r;
        logic [LANE_W-1:0] dat_r;

        psram_lane_writer #(
            .IDX_W  (IDX_W),
            .LANE_W (LANE_W)
        ) u_writer (
            .clk         (clk),
            .rst_n       (rst_n),
            .win_now     (lane_win[g]),
            .idx_now     (idx_now),
            .din         (wdata[g*LANE_W +: LANE_W]),
            .commit      (commit),
            .commit_idx  (commit_idx),
            .commit_data (commit_data)
        );

        psram_lane_store #(
            .DEPTH  (DEPTH),
            .IDX_W  (IDX_W),
            .LANE_W (LANE_W)
        ) u_store (
            .clk     (clk),
            .wr_en   (commit),
            .wr_idx  (commit_idx),
            .wr_data (commit_data),
            .rd_idx  (idx_now),
            .rd_data (rd_byte)
        );

        // Register the lane's read byte and drive flag; undriven lanes read zero
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                drv_r <= 1'b0;
                dat_r <= '0;
            end else if (lane_rd[g]) begin
                drv_r <= 1'b1;
                dat_r <= rd_byte;
            end else begin
                drv_r <= 1'b0;
                dat_r <= '0;
            end
        end

        assign lane_drive[g]                  = drv_r;
        assign rdata[g*LANE_W +: LANE_W]      = dat_r;
    end

    // Register the power state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_q <= 1'b0;
        end else begin
            power_q <= active_now;
        end
    end

    assign power_active = power_q;

endmodule

// File: rtl/bytelane_psram_port_checker.sv
`timescale 1ns/1ps
// Property checker for bytelane_psram_port, attached with bind below.
// Assumes: outputs after an edge reflect the controls sampled on that edge.
module bytelane_psram_port_checker #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        chip_sel_n,
    input logic                        wr_n,
    input logic                        out_en_n,
    input logic [NUM_LANES-1:0]        lane_en_n,
    input logic [LANE_W*NUM_LANES-1:0] rdata,
    input logic [NUM_LANES-1:0]        lane_drive,
    input logic                        power_active
);

    // R3
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(chip_sel_n)) |-> (lane_drive == '0));

    // R3
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!chip_sel_n && !wr_n)) |-> (lane_drive == '0));

    // R3
    oe_off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(out_en_n)) |-> (lane_drive == '0));

    // R2
    read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!chip_sel_n && wr_n && !out_en_n))
        |-> (lane_drive == ~$past(lane_en_n)));

    // R8
    power_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (power_active == $past(!chip_sel_n && !(&lane_en_n))));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lane_drive == '0 && !power_active && rdata == '0));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_zero
        // R3
        undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_drive[g] |-> (rdata[g*LANE_W +: LANE_W] == '0));
    end

endmodule

bind bytelane_psram_port bytelane_psram_port_checker #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_sel_n   (chip_sel_n),
    .wr_n         (wr_n),
    .out_en_n     (out_en_n),
    .lane_en_n    (lane_en_n),
    .rdata        (rdata),
    .lane_drive   (lane_drive),
    .power_active (power_active)
);

// File: tb/bytelane_psram_port_bench.sv
`timescale 1ns/1ps
// Self-checking bench: small array, edge-by-edge control sequences, an
// exhaustive control sweep and byte-masked write sweeps, all compared with a
// reference array driven by the requirements.
module bytelane_psram_port_bench;

    localparam int ADDR_W = 18;
    localparam int NL     = 2;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_sel_n = 1'b1;
    logic              wr_n = 1'b1;
    logic              out_en_n = 1'b1;
    logic [NL-1:0]     lane_en_n = 2'b11;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic [NL-1:0]     lane_drive;
    logic              power_active;

    logic [15:0] ref_mem [DEPTH];
    logic [NL-1:0] m_win = '0;
    int          m_idx [NL];
    int          checks = 0;
    int          failures = 0;
    bit          done = 0;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    bytelane_psram_port #(
        .ADDR_W    (ADDR_W),
        .LANE_W    (8),
        .NUM_LANES (NL),
        .DEPTH     (DEPTH)
    ) u_bytelane_psram_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_sel_n   (chip_sel_n),
        .wr_n         (wr_n),
        .out_en_n     (out_en_n),
        .lane_en_n    (lane_en_n),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .lane_drive   (lane_drive),
        .power_active (power_active)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:8];
    endfunction

    // One clock edge: apply controls, update the reference, compare after the edge
    task automatic step(input logic cs_n, input logic we_n, input logic oe_n,
                        input logic [NL-1:0] en_n, input logic [ADDR_W-1:0] a,
                        input logic [15:0] d, input string tag);
        logic [NL-1:0] exp_drv;
        logic [15:0]   exp_rd;
        logic          exp_pw;
        logic          rd;
        int            idx;
        chip_sel_n = cs_n;
        wr_n       = we_n;
        out_en_n   = oe_n;
        lane_en_n  = en_n;
        addr       = a;
        wdata      = d;
        idx        = int'(a % DEPTH);
        for (int i = 0; i < NL; i++) begin
            logic w_now;
            w_now = !cs_n && !we_n && !en_n[i];
            if (m_win[i] && !w_now) ref_mem[m_idx[i]][i*8 +: 8] = d[i*8 +: 8];
            if (w_now) m_idx[i] = idx;
            m_win[i] = w_now;
        end
        rd      = !cs_n && we_n && !oe_n;
        exp_drv = rd ? ~en_n : '0;
        exp_rd  = '0;
        for (int i = 0; i < NL; i++) begin
            if (exp_drv[i]) exp_rd[i*8 +: 8] = ref_mem[idx][i*8 +: 8];
        end
        exp_pw = !cs_n && !(&en_n);
        @(posedge clk);
        #1;
        check(tag, "lane_drive", 32'(lane_drive), 32'(exp_drv));
        check(tag, "rdata", 32'(rdata), 32'(exp_rd));
        check("R8", "power_active", 32'(power_active), 32'(exp_pw));
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 1'b1, 2'b11, '0, '0, "R3");
    endtask

    // Full-word write: junk during the window, real data on the closing edge
    task automatic write_word(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        step(1'b0, 1'b0, 1'b1, 2'b00, a, ~d, "R5");
        step(1'b0, 1'b1, 1'b1, 2'b00, a, d, "R5");
    endtask

    // Reset for one edge with the outputs checked cleared
    task automatic do_reset();
        rst_n = 1'b0;
        chip_sel_n = 1'b1;
        wr_n = 1'b1;
        out_en_n = 1'b1;
        lane_en_n = 2'b11;
        m_win = '0;
        @(posedge clk);
        #1;
        check("R9", "lane_drive", 32'(lane_drive), 32'd0);
        check("R9", "rdata", 32'(rdata), 32'd0);
        check("R9", "power_active", 32'(power_active), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #3;
        do_reset();

        // R5: fill every word, data taken only on the closing edge
        for (int a = 0; a < DEPTH; a++) write_word(18'(a), 16'(a * 16'h1357 + 16'h0F0F));
        // R2, R1: full reads then each lane alone
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, 1'b0, 2'b00, 18'(a), '0, "R2");
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, 1'b0, 2'b10, 18'(a), '0, "R1");
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, 1'b0, 2'b01, 18'(a), '0, "R1");

        // R4, R6: byte-masked writes ended by write strobe, chip select or lane enable
        for (int a = 0; a < DEPTH; a++) begin
            for (int kind = 0; kind < 3; kind++) begin
                logic [NL-1:0] msk;
                logic [15:0]   d;
                msk = 2'(((a + kind) % 3) + 1);
                d   = next_rand();
                step(1'b0, 1'b0, 1'b1, ~msk, 18'(a), ~d, "R4");
                step(1'b0, 1'b0, 1'b1, ~msk, 18'(a), next_rand(), "R5");
                case (kind)
                    0: step(1'b0, 1'b1, 1'b1, ~msk, 18'(a), d, "R6");
                    1: step(1'b1, 1'b0, 1'b1, ~msk, 18'(a), d, "R6");
                    default: step(1'b0, 1'b0, 1'b1, 2'b11, 18'(a), d, "R6");
                endcase
                idle();
            end
        end
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, 1'b0, 2'b00, 18'(a), '0, "R4");

        // R6: high lane enable lifts first, low lane window continues
        step(1'b0, 1'b0, 1'b1, 2'b00, 18'd9, 16'h0000, "R6");
        step(1'b0, 1'b0, 1'b1, 2'b10, 18'd9, 16'hC3FF, "R6");
        step(1'b0, 1'b0, 1'b1, 2'b10, 18'd9, 16'h1111, "R6");
        step(1'b0, 1'b1, 1'b1, 2'b10, 18'd9, 16'h005A, "R6");
        step(1'b0, 1'b1, 1'b0, 2'b00, 18'd9, '0, "R6");
        check("R6", "word9", 32'(ref_mem[9]), 32'h0000_C35A);

        // R7: write strobe rises on the edge that starts a read of the same word
        step(1'b0, 1'b0, 1'b0, 2'b00, 18'd4, 16'hFFFF, "R7");
        step(1'b0, 1'b1, 1'b0, 2'b00, 18'd4, 16'hBEEF, "R7");
        step(1'b0, 1'b1, 1'b0, 2'b00, 18'd4, '0, "R7");
        check("R7", "word4", 32'(ref_mem[4]), 32'h0000_BEEF);

        // R10: addresses above the depth alias lower words
        write_word(18'(DEPTH + 3), 16'hA1B2);
        step(1'b0, 1'b1, 1'b0, 2'b00, 18'd3, '0, "R10");
        write_word(18'h20005, 16'h7E81);
        step(1'b0, 1'b1, 1'b0, 2'b00, 18'd5, '0, "R10");
        check("R10", "word5", 32'(ref_mem[5]), 32'h0000_7E81);

        // R9: reset in the middle of a window discards it
        step(1'b0, 1'b0, 1'b1, 2'b00, 18'd5, 16'h0000, "R9");
        do_reset();
        wdata = 16'hDEAD;
        step(1'b0, 1'b1, 1'b0, 2'b00, 18'd5, '0, "R9");
        check("R9", "word5_kept", 32'(ref_mem[5]), 32'h0000_7E81);

        // R3, R8: every combination of the five control levels
        for (int c = 0; c < 32; c++) begin
            logic [4:0] v;
            v = 5'(c);
            step(v[4], v[3], v[2], v[1:0], 18'd7, 16'(c * 16'h0909 + 16'h3C), "R3");
        end
        idle();
        step(1'b0, 1'b1, 1'b0, 2'b00, 18'd7, '0, "R3");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule